// File: doc/BRIEF.md
# Audio Sample Record and Playback Sequencer

This block sequences sound capture and replay through a single-port sample RAM that is external to the block. A record request makes it sweep the whole address range once. On every cycle of that sweep it strobes the converter that digitises the input, lets that converter drive the shared data bus, and commands a write at the current address. A play request sweeps the same range with read accesses instead. One cycle after each read, while the RAM's registered read data sits on the bus, the block strobes the output converter so that it captures the word.

Both sweeps share one address counter, which is reset to zero whenever a sweep begins. The block raises a one-cycle completion flag when a sweep is over and then waits for the next request. It never drives data itself: the RAM, both converters and the bus are outside the block, and the block only times their control strobes.

Top module: `audio_sweep_ctrl`

## Requirements
- R1: Every sweep issues its first RAM access at address 0, whatever address the previous sweep ended on.
- R2: In each record cycle the block asserts the input-converter load, the input-converter bus drive, the RAM enable and the RAM read/write line, all high together. On the read/write line, 1 means write.
- R3: In each play cycle the block asserts the RAM enable with the read/write line at 0 (read). The input-converter load and the bus drive stay low.
- R4: The output-converter load goes high in the cycle right after each RAM read, and only then, so that it captures the word read at the preceding address.
- R5: Within a sweep the address rises by one each cycle. Exactly 2^AW accesses are made, covering 0 to 2^AW-1, and the last access is at the all-ones address.
- R6: done_o pulses for exactly one cycle per sweep. For a record sweep it comes in the cycle after the last write. For a play sweep it comes in the cycle after the last output-converter load.
- R7: While idle, the RAM enable, the read/write line, both input-converter strobes and the output-converter load are all low.
- R8: If rec_i and play_i are sampled high together in idle, a record sweep starts.
- R9: Start requests that arrive during a sweep, including the trailing output-load cycle of a play sweep, have no effect.
- R10: A record sweep followed by a play sweep presents to the output converter the recorded samples, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_i | input | 1 | Request a record sweep (sampled in idle) |
| play_i | input | 1 | Request a play sweep (sampled in idle) |
| adc_load_o | output | 1 | Strobe the input converter to latch a new sample |
| adc_drive_o | output | 1 | Let the input converter drive the shared data bus |
| ram_addr_o | output | AW | RAM word address |
| ram_wr_o | output | 1 | RAM read/write: 1 write, 0 read |
| ram_en_o | output | 1 | RAM access enable |
| dac_load_o | output | 1 | Strobe the output converter to capture the bus |
| done_o | output | 1 | One-cycle sweep completion pulse |

## Verification
Some relations are checked by assertions on every cycle. Writes always come with both input-converter strobes, and reads never come with the bus drive. Each read is followed by an output-converter load, and each such load is preceded by a read. Accesses step the address by one until the all-ones address, after which access stops. Every sweep begins at zero, the idle state stays quiet, and done_o never lasts two cycles. Other properties only the bench's scenarios can show. These are the request priority, the discarding of requests made mid-sweep or during the trailing load, the exact cycle of the done pulse, and the data round trip. For that round trip the bench compares the words recorded through a behavioural RAM and converter model against what the output converter captures when they are played back.

// File: rtl/audio_sweep_ctrl.sv
module audio_sweep_ctrl #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_i,
  input  logic          play_i,
  output logic          adc_load_o,
  output logic          adc_drive_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_wr_o,
  output logic          ram_en_o,
  output logic          dac_load_o,
  output logic          done_o
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_REC, S_PLAY, S_DRAIN} state_t;

  state_t        st;
  logic [AW-1:0] addr;
  logic          at_end;
  logic          dac_q;
  logic          done_q;

  assign at_end = (addr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      dac_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dac_q  <= (st == S_PLAY);
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (rec_i) begin
            st   <= S_REC;
            addr <= '0;
          end else if (play_i) begin
            st   <= S_PLAY;
            addr <= '0;
          end
        end
        S_REC: begin
          if (at_end) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        S_PLAY: begin
          if (at_end) st <= S_DRAIN;
          else        addr <= addr + 1'b1;
        end
        S_DRAIN: begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign adc_load_o  = (st == S_REC);
  assign adc_drive_o = (st == S_REC);
  assign ram_wr_o    = (st == S_REC);
  assign ram_en_o    = (st == S_REC) || (st == S_PLAY);
  assign ram_addr_o  = addr;
  assign dac_load_o  = dac_q;
  assign done_o      = done_q;

  a_r1_sweep_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_en_o) |-> ram_addr_o == '0);

  a_r2_write_with_adc: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_o |-> (ram_en_o && adc_load_o && adc_drive_o));

  a_r3_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && !ram_wr_o) |-> (!adc_drive_o && !adc_load_o));

  a_r4_dac_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && !ram_wr_o) |=> dac_load_o);

  a_r4_dac_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load_o |-> $past(ram_en_o && !ram_wr_o));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && ram_addr_o != LAST) |=>
      (ram_en_o && ram_addr_o == $past(ram_addr_o) + 1'b1));

  a_r5_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en_o && ram_addr_o == LAST) |=> !ram_en_o);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_en_o |-> (!ram_wr_o && !adc_load_o && !adc_drive_o));

endmodule

// File: tb/audio_sweep_ctrl_tb_top.sv
module audio_sweep_ctrl_tb_top;
  localparam int  AW   = 10;
  localparam int  N    = 1 << AW;
  localparam time TCLK = 10;

  logic          clk, rst_n, rec_i, play_i;
  logic          adc_load, adc_drive, ram_wr, ram_en, dac_load, done;
  logic [AW-1:0] ram_addr;

  logic [15:0] mem [N];
  logic [15:0] rdata, adc_q, bus;
  int          adc_cnt;
  int          total, bad;
  bit          finished;

  audio_sweep_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rec_i(rec_i), .play_i(play_i),
    .adc_load_o(adc_load), .adc_drive_o(adc_drive), .ram_addr_o(ram_addr),
    .ram_wr_o(ram_wr), .ram_en_o(ram_en), .dac_load_o(dac_load), .done_o(done)
  );

  function automatic logic [15:0] sample(int k);
    return 16'((k * 40503 + 977) ^ 16'hC3A5);
  endfunction

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  initial begin
    adc_cnt = 0;
    adc_q   = sample(0);
    rdata   = '0;
  end

  assign bus = adc_drive ? adc_q : rdata;

  always @(posedge clk) begin
    if (adc_load) begin
      adc_cnt <= adc_cnt + 1;
      adc_q   <= sample(adc_cnt + 1);
    end
    if (ram_en) begin
      if (ram_wr) mem[ram_addr] <= bus;
      else        rdata <= mem[ram_addr];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(string req);
    chk(!ram_en && !ram_wr && !adc_load && !adc_drive && !dac_load, req,
        {ram_en, ram_wr, adc_load, adc_drive, dac_load}, 0);
  endtask

  task automatic start(bit r, bit p);
    @(negedge clk); rec_i = r; play_i = p;
    @(negedge clk); rec_i = 0; play_i = 0;
  endtask

  task automatic run_record(int base, bit inject);
    for (int c = 0; c < N; c++) begin
      chk(ram_en && ram_wr && adc_load && adc_drive && !dac_load, "R2",
          {ram_en, ram_wr, adc_load, adc_drive, dac_load}, 5'b11110);
      chk(ram_addr == AW'(c), (c == 0) ? "R1" : "R5", ram_addr, c);
      chk(bus == sample(base + c), "R10", bus, sample(base + c));
      chk(!done, "R6", done, 0);
      if (inject && c == N/2) play_i = 1;
      @(negedge clk);
      play_i = 0;
    end
    chk(done && !ram_en, "R6", {done, ram_en}, 2'b10);
    @(negedge clk);
    chk(!done, "R6", done, 0);
    idle_check("R9");
  endtask

  task automatic run_play(int base, bit inject);
    for (int c = 0; c < N; c++) begin
      chk(ram_en && !ram_wr && !adc_load && !adc_drive, "R3",
          {ram_en, ram_wr, adc_load, adc_drive}, 4'b1000);
      chk(ram_addr == AW'(c), (c == 0) ? "R1" : "R5", ram_addr, c);
      chk(dac_load == (c != 0), "R4", dac_load, c != 0);
      if (c != 0) chk(bus == sample(base + c - 1), "R10", bus, sample(base + c - 1));
      chk(!done, "R6", done, 0);
      if (inject && c == 7) rec_i = 1;
      @(negedge clk);
      rec_i = 0;
    end
    chk(!ram_en && dac_load && !done, "R4", {ram_en, dac_load, done}, 3'b010);
    chk(bus == sample(base + N - 1), "R10", bus, sample(base + N - 1));
    if (inject) rec_i = 1;
    @(negedge clk);
    rec_i = 0;
    chk(done && !dac_load && !ram_en, "R6", {done, dac_load, ram_en}, 3'b100);
    @(negedge clk);
    chk(!done, "R6", done, 0);
    idle_check("R9");
  endtask

  initial begin
    int base;
    total = 0; bad = 0; finished = 0;
    rec_i = 0; play_i = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    idle_check("R7");
    chk(!done, "R7", done, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      idle_check("R7");
    end

    base = adc_cnt;
    start(1, 0);
    run_record(base, 1);
    for (int a = 0; a < N; a++)
      chk(mem[a] == sample(base + a), "R10", mem[a], sample(base + a));

    start(0, 1);
    run_play(base, 1);

    base = adc_cnt;
    start(1, 1);
    chk(ram_wr, "R8", ram_wr, 1);
    run_record(base, 0);

    start(0, 1);
    run_play(base, 0);

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle_check("R7");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule